// File: doc/BRIEF.md
# Clock Start-Up Sequencer

This block gates instruction execution until the selected system clock source is trustworthy. It reads two static configuration inputs: a 4-bit clock-source code and a 2-bit start-up code. From these it derives two waits. The first is a supply-settling wait, counted on a slow, free-running watchdog oscillator clock. The second is an oscillator-stabilisation wait, counted on the system clock itself. The result is a single run-enable output that the core uses as its execution gate.

After a power-on or external reset, both waits run in sequence. The watchdog-clocked wait runs first, and its completion flag crosses into the system-clock domain through a flop synchroniser. The system-clock count starts after that flag arrives. After a wake-up from deep sleep, only the system-clock count is repeated.

A configuration that hits a reserved code raises a configuration-error flag and falls back to the longest available waits. The out-of-reset defaults scale the counts to 4,096 and 65,536 watchdog cycles and to 6 through 32,768 clocks. A typical configuration is source 0001 with start-up code 10, which selects an internal RC source with a slowly rising supply: 6 clocks after a 65,536-cycle wait.

Top module: `clk_startup_seq`

## Requirements
- R1: While `rst_n` is low, `run_en` and `cfg_err` are 0.
- R2: The crystal/resonator class covers source codes 1010 to 1111. Bit 0 of the source code, followed by the start-up code, selects the clock count and the settling wait, as {bit0,sut}: 000 = 258 + short, 001 = 258 + long, 010 = 1K + none, 011 = 1K + short, 100 = 1K + long, 101 = 16K + none, 110 = 16K + short, 111 = 16K + long.
- R3: Source code 1001 (low-frequency crystal) uses these start-up codes: 00 = 1K + short, 01 = 1K + long, 10 = 32K + long. Code 11 is reserved.
- R4: Source codes 0101 to 1000 (external RC) use these start-up codes: 00 = 18 + none, 01 = 18 + short, 10 = 18 + long, 11 = 6 + short.
- R5: Source codes 0000 to 0100 (internal RC and external clock) use a clock count of 6. Start-up codes 00, 01 and 10 select no, short and long settling waits. Code 11 is reserved.
- R6: A reserved code drives `cfg_err` to 1 and applies the long settling wait plus the 32K clock count. Every other code drives `cfg_err` to 0.
- R7: After reset release, `run_en` rises only after the settling wait has completed on `wdt_clk` and the full clock count has elapsed on `clk`. The wait is 0, WD_SHORT_CYC or WD_LONG_CYC watchdog cycles.
- R8: A `sleep_req` sampled while `run_en` is 1 drives `run_en` to 0 on the next clock edge. `run_en` stays 0 until a wake-up.
- R9: A `wake_req` sampled while the block is asleep restarts only the clock count. `run_en` rises exactly the selected clock count of `clk` edges after the edge that sampled the wake-up.
- R10: `wake_req` has no effect while the block is running, and `sleep_req` has no effect during a start-up count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock from the selected source |
| rst_n | input | 1 | Asynchronous active-low power-on/external reset |
| wdt_clk | input | 1 | Slow watchdog oscillator clock |
| src_sel | input | 4 | Static clock-source code |
| sut_sel | input | 2 | Static start-up-time code |
| sleep_req | input | 1 | Request to enter deep sleep (single cycle) |
| wake_req | input | 1 | Wake-up event from deep sleep (single cycle) |
| run_en | output | 1 | Execution enable; 1 when the clock is usable |
| cfg_err | output | 1 | Reserved configuration code detected |

## Verification
The bench walks every one of the 64 code pairs with counts scaled so that every distinct combination of clock count and settling wait gives a total at least 30 cycles apart from any other. A swapped table entry, a wrong class boundary or a dropped settling wait therefore moves the reset-to-run time outside the accepted window. For each pair, the bench also sends the block to sleep and wakes it, timing the wake-up exactly in cycles. A design that repeated the watchdog wait on wake-up, or that was off by one clock in its terminal count, would miss that exact value. The bench also pokes the ignored inputs: a sleep request during start-up must not stall the count, and a wake pulse while running must not drop `run_en`. Finally, the reserved codes must raise `cfg_err` and take the longest path.

// File: rtl/stup_pkg.sv
package stup_pkg;

  typedef enum logic [1:0] {
    WD_NONE  = 2'd0,
    WD_SHORT = 2'd1,
    WD_LONG  = 2'd2
  } wd_len_e;

  typedef enum logic [2:0] {
    CKL_6   = 3'd0,
    CKL_18  = 3'd1,
    CKL_258 = 3'd2,
    CKL_1K  = 3'd3,
    CKL_16K = 3'd4,
    CKL_32K = 3'd5
  } ck_len_e;

  typedef struct packed {
    wd_len_e wd;
    ck_len_e ck;
    logic    rsvd;
  } stup_plan_t;

  // Map a source code and a start-up code onto the two waits.
  function automatic stup_plan_t decode_plan(input logic [3:0] src, input logic [1:0] sut);
    stup_plan_t p;
    p.wd   = WD_LONG;
    p.ck   = CKL_32K;
    p.rsvd = 1'b0;
    if (src >= 4'd10) begin
      unique case ({src[0], sut})
        3'b000:  begin p.ck = CKL_258; p.wd = WD_SHORT; end
        3'b001:  begin p.ck = CKL_258; p.wd = WD_LONG;  end
        3'b010:  begin p.ck = CKL_1K;  p.wd = WD_NONE;  end
        3'b011:  begin p.ck = CKL_1K;  p.wd = WD_SHORT; end
        3'b100:  begin p.ck = CKL_1K;  p.wd = WD_LONG;  end
        3'b101:  begin p.ck = CKL_16K; p.wd = WD_NONE;  end
        3'b110:  begin p.ck = CKL_16K; p.wd = WD_SHORT; end
        default: begin p.ck = CKL_16K; p.wd = WD_LONG;  end
      endcase
    end else if (src == 4'd9) begin
      unique case (sut)
        2'b00:   begin p.ck = CKL_1K;  p.wd = WD_SHORT; end
        2'b01:   begin p.ck = CKL_1K;  p.wd = WD_LONG;  end
        2'b10:   begin p.ck = CKL_32K; p.wd = WD_LONG;  end
        default: p.rsvd = 1'b1;
      endcase
    end else if (src >= 4'd5) begin
      unique case (sut)
        2'b00:   begin p.ck = CKL_18; p.wd = WD_NONE;  end
        2'b01:   begin p.ck = CKL_18; p.wd = WD_SHORT; end
        2'b10:   begin p.ck = CKL_18; p.wd = WD_LONG;  end
        default: begin p.ck = CKL_6;  p.wd = WD_SHORT; end
      endcase
    end else begin
      unique case (sut)
        2'b00:   begin p.ck = CKL_6; p.wd = WD_NONE;  end
        2'b01:   begin p.ck = CKL_6; p.wd = WD_SHORT; end
        2'b10:   begin p.ck = CKL_6; p.wd = WD_LONG;  end
        default: p.rsvd = 1'b1;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/stup_rst_sync.sv
module stup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/stup_sync.sv
module stup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/stup_wdt_phase.sv
module stup_wdt_phase
  import stup_pkg::*;
#(
  parameter int SHORT_CYC = 4096,
  parameter int LONG_CYC  = 65536
) (
  input  logic    wdt_clk,
  input  logic    rst_n,
  input  wd_len_e wd_sel,
  output logic    done
);
  localparam int WW = $clog2(LONG_CYC + 1);

  logic [WW-1:0] tgt, cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    unique case (wd_sel)
      WD_SHORT: tgt = WW'(SHORT_CYC);
      WD_LONG:  tgt = WW'(LONG_CYC);
      default:  tgt = '0;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!done_q) begin
      if (cnt_q == tgt) done_d = 1'b1;
      else              cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R7
  wd_count_bound_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    cnt_q <= tgt);

  // R9
  wd_done_sticky_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/stup_clk_phase.sv
module stup_clk_phase
  import stup_pkg::*;
#(
  parameter int CK_T6    = 6,
  parameter int CK_T18   = 18,
  parameter int CK_T258  = 258,
  parameter int CK_T1K   = 1024,
  parameter int CK_T16K  = 16384,
  parameter int CK_T32K  = 32768
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ck_len_e ck_sel,
  input  logic    wdt_ok,
  input  logic    sleep_req,
  input  logic    wake_req,
  output logic    run_en
);
  localparam int CW = $clog2(CK_T32K + 1);

  typedef enum logic [1:0] {
    PH_WDT = 2'd0,
    PH_CNT = 2'd1,
    PH_RUN = 2'd2,
    PH_SLP = 2'd3
  } phase_e;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d, tgt, last;
  logic          run_q, run_d;

  always_comb begin
    unique case (ck_sel)
      CKL_6:   tgt = CW'(CK_T6);
      CKL_18:  tgt = CW'(CK_T18);
      CKL_258: tgt = CW'(CK_T258);
      CKL_1K:  tgt = CW'(CK_T1K);
      CKL_16K: tgt = CW'(CK_T16K);
      default: tgt = CW'(CK_T32K);
    endcase
  end

  assign last = tgt - 1'b1;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    run_d = run_q;
    unique case (ph_q)
      PH_WDT: if (wdt_ok) begin
        ph_d  = PH_CNT;
        cnt_d = '0;
      end
      PH_CNT: begin
        if (cnt_q == last) begin
          ph_d  = PH_RUN;
          run_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_RUN: if (sleep_req) begin
        ph_d  = PH_SLP;
        run_d = 1'b0;
      end
      default: if (wake_req) begin
        ph_d  = PH_CNT;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_WDT;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign run_en = run_q;

  // R8
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && sleep_req) |=> !run_q);

  // R9
  terminal_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(cnt_q) == last));

  // R7
  settle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> wdt_ok);
endmodule

// File: rtl/clk_startup_seq.sv
module clk_startup_seq
  import stup_pkg::*;
#(
  parameter int WD_SHORT_CYC = 4096,
  parameter int WD_LONG_CYC  = 65536,
  parameter int CK_T6        = 6,
  parameter int CK_T18       = 18,
  parameter int CK_T258      = 258,
  parameter int CK_T1K       = 1024,
  parameter int CK_T16K      = 16384,
  parameter int CK_T32K      = 32768,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_clk,
  input  logic [3:0] src_sel,
  input  logic [1:0] sut_sel,
  input  logic       sleep_req,
  input  logic       wake_req,
  output logic       run_en,
  output logic       cfg_err
);
  stup_plan_t plan;
  logic       rst_sys_n, rst_wdt_n;
  logic       wdt_done, wdt_ok;
  logic       err_q;

  assign plan = decode_plan(src_sel, sut_sel);

  stup_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_sys (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_sys_n));

  stup_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_wdt (
    .clk(wdt_clk), .arst_n(rst_n), .srst_n(rst_wdt_n));

  stup_wdt_phase #(.SHORT_CYC(WD_SHORT_CYC), .LONG_CYC(WD_LONG_CYC)) u_wdt (
    .wdt_clk(wdt_clk), .rst_n(rst_wdt_n), .wd_sel(plan.wd), .done(wdt_done));

  stup_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .rst_n(rst_sys_n), .d(wdt_done), .q(wdt_ok));

  stup_clk_phase #(
    .CK_T6(CK_T6), .CK_T18(CK_T18), .CK_T258(CK_T258),
    .CK_T1K(CK_T1K), .CK_T16K(CK_T16K), .CK_T32K(CK_T32K)
  ) u_clk (
    .clk(clk), .rst_n(rst_sys_n), .ck_sel(plan.ck), .wdt_ok(wdt_ok),
    .sleep_req(sleep_req), .wake_req(wake_req), .run_en(run_en));

  always_ff @(posedge clk or negedge rst_sys_n) begin
    if (!rst_sys_n) err_q <= 1'b0;
    else            err_q <= plan.rsvd;
  end

  assign cfg_err = err_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!run_en && !cfg_err));
endmodule

// File: tb/clk_startup_seq_tb.sv
module clk_startup_seq_tb;
  localparam int WS = 75, WL = 175;
  localparam int C6 = 6, C18 = 36, C258 = 66, C1K = 96, C16K = 126, C32K = 156;
  localparam int WDT_RATIO = 4;
  localparam int SLACK = 24;

  logic clk = 1'b0, wdt_clk = 1'b0, rst_n = 1'b0;
  logic [3:0] src_sel = 4'd0;
  logic [1:0] sut_sel = 2'd0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic run_en, cfg_err;
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  always #20 wdt_clk = ~wdt_clk;

  clk_startup_seq #(
    .WD_SHORT_CYC(WS), .WD_LONG_CYC(WL), .CK_T6(C6), .CK_T18(C18),
    .CK_T258(C258), .CK_T1K(C1K), .CK_T16K(C16K), .CK_T32K(C32K)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_clk(wdt_clk), .src_sel(src_sel),
    .sut_sel(sut_sel), .sleep_req(sleep_req), .wake_req(wake_req),
    .run_en(run_en), .cfg_err(cfg_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected clock count, settling wait in watchdog cycles, reserved flag, class tag.
  task automatic expect_cfg(input int s, input int u, output int c, output int w,
                            output bit rsv, output string tag);
    int sh, lg, nn;
    sh = WS; lg = WL; nn = 0; rsv = 0;
    if (s >= 10) begin
      tag = "R2";
      case ({s[0], u[1:0]})
        3'b000: begin c = C258; w = sh; end
        3'b001: begin c = C258; w = lg; end
        3'b010: begin c = C1K;  w = nn; end
        3'b011: begin c = C1K;  w = sh; end
        3'b100: begin c = C1K;  w = lg; end
        3'b101: begin c = C16K; w = nn; end
        3'b110: begin c = C16K; w = sh; end
        default: begin c = C16K; w = lg; end
      endcase
    end else if (s == 9) begin
      tag = "R3";
      case (u)
        0: begin c = C1K;  w = sh; end
        1: begin c = C1K;  w = lg; end
        2: begin c = C32K; w = lg; end
        default: begin c = C32K; w = lg; rsv = 1; end
      endcase
    end else if (s >= 5) begin
      tag = "R4";
      case (u)
        0: begin c = C18; w = nn; end
        1: begin c = C18; w = sh; end
        2: begin c = C18; w = lg; end
        default: begin c = C6; w = sh; end
      endcase
    end else begin
      tag = "R5";
      case (u)
        0: begin c = C6; w = nn; end
        1: begin c = C6; w = sh; end
        2: begin c = C6; w = lg; end
        default: begin c = C32K; w = lg; rsv = 1; end
      endcase
    end
    if (rsv) tag = "R6";
  endtask

  task automatic run_cfg(input int s, input int u, input bit poke);
    int c, w, e, n, m;
    bit rsv, hit;
    string tag;
    expect_cfg(s, u, c, w, rsv, tag);
    e = WDT_RATIO * w + c;
    @(negedge clk);
    rst_n = 1'b0; src_sel = 4'(s); sut_sel = 2'(u);
    sleep_req = 1'b0; wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(run_en == 1'b0, "R1", "run_en in reset", int'(run_en), 0);
    chk(cfg_err == 1'b0, "R1", "cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    n = 0; hit = 0;
    while (!hit && n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
      sleep_req = (poke && n == 5);
      if (run_en) hit = 1;
    end
    sleep_req = 1'b0;
    chk(n >= e && n <= e + SLACK, tag, "R7 reset-to-run cycles", n, e);
    if (poke) chk(n >= e && n <= e + SLACK, "R10", "sleep during start-up", n, e);
    chk(cfg_err == rsv, "R6", "cfg_err level", int'(cfg_err), int'(rsv));
    // wake pulse while running is ignored
    wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(run_en == 1'b1, "R10", "wake while running", int'(run_en), 1);
    // sleep entry
    sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    chk(run_en == 1'b0, "R8", "run_en after sleep", int'(run_en), 0);
    repeat (5) @(negedge clk);
    chk(run_en == 1'b0, "R8", "run_en held in sleep", int'(run_en), 0);
    // wake-up: clock count only
    wake_req = 1'b1;
    @(posedge clk);
    @(negedge clk); wake_req = 1'b0;
    m = 0; hit = 0;
    while (!hit && m < 3000) begin
      @(posedge clk); m++;
      @(negedge clk);
      if (run_en) hit = 1;
    end
    chk(m == c, "R9", "wake-to-run cycles", m, c);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      for (int u = 0; u < 4; u++) begin
        run_cfg(s, u, (u == 1) && (s == 3 || s == 12));
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule